// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with a registered read path and a two-bit burst address generator. A transfer opens when either of two address strobes is sampled low at a rising clock edge. The processor-side strobe only counts while the primary select is active. The controller-side strobe counts regardless of that select. Once a transfer is open, each further clock edge makes one access. The access goes to the loaded address with its low two bits replaced by a burst offset. The offset steps when the advance input is low and holds when it is high.

A word is 36 bits, split into four 9-bit byte lanes. A write can cover all four lanes through a global write input, or a chosen subset of lanes through a lane-write enable together with per-lane selects. Read data comes out of an output register one edge after the access edge, so the first beat of a burst appears after the pipeline delay and each following beat one clock later. An asynchronous drive enable gates only the output-enable flag.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high, and after its last high edge until the first read, `dout_vld` and `dout_oe` are 0.
- R2: A read access made at clock edge N presents the word stored at the accessed address on `dout`, with `dout_vld` high, after edge N+1. Data written at edge N is returned by a read at edge N+1 or later.
- R3: `burst_linear`=1 at the opening edge selects linear order: the low two address bits of an access are (start low bits + offset) mod 4. The offset is 0 at the opening edge, increments by one on each later edge with `advance_n` low, and holds when `advance_n` is high.
- R4: `burst_linear`=0 at the opening edge selects interleaved order: the low two address bits are start low bits XOR offset. For example, a start of 01 gives 01, 00, 11, 10.
- R5: `wr_all_n` low writes all four lanes of `din`, whatever `wr_lane_en_n` and `lane_sel_n` hold.
- R6: With `wr_all_n` high and `wr_lane_en_n` low, each lane i with `lane_sel_n[i]` low is written from `din[9*i+8:9*i]`. Unselected lanes keep their old content. An access with no lane selected is a read.
- R7: `strobe_cpu_n` low while `sel_n` is high is ignored: an open burst continues as if no strobe were present.
- R8: An opening made by `strobe_cpu_n` (with `sel_n` low) is always a read and takes priority over `strobe_ctl_n`. A write for such a transfer is made on a following edge with the write controls of that edge. An opening made by `strobe_ctl_n` alone writes at the opening edge if write controls are present.
- R9: An opening edge at which the chip is not selected (`sel_n` high, `sel_hi` low or `sel2_n` high) closes the transfer. `dout_vld` is then 0 after the next edge.
- R10: `dout_oe` equals `dout_vld` AND NOT `drv_en_n` at all times. `drv_en_n` changes neither `dout` nor the read pipeline.
- R11: While no transfer is open, edges without a valid opening strobe neither write the array nor start a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Word address loaded at an opening edge |
| din | input | 36 | Write data, four 9-bit lanes |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Expansion select, active high |
| sel2_n | input | 1 | Expansion select, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Burst offset step, active low |
| wr_lane_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| wr_all_n | input | 1 | Writes all lanes, active low |
| drv_en_n | input | 1 | Asynchronous output drive enable, active low |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| dout | output | 36 | Registered read data |
| dout_vld | output | 1 | `dout` holds the result of a read |
| dout_oe | output | 1 | Output drivers enabled |

## Verification
A write and a read of the same word can land on consecutive edges, and a partial write can land on the same edge that the output register latches an earlier read of that word. The bench provokes this with random bursts that mix lane writes, held offsets and advances on a small 64-word window, so collisions are frequent. The returned word is judged against a bench array. That array is updated only after the expected output of the edge has been taken from it, so a read must return the value from before the write made on the same edge. A second overlap, a deselect arriving while read beats are still in the pipeline, is judged by requiring the beat already in flight to appear and `dout_vld` to fall on the edge after it.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int unsigned SRAM_ADDR_W  = 10;
    localparam int unsigned SRAM_LANES   = 4;
    localparam int unsigned SRAM_LANE_W  = 9;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic       open;
        logic       linear;
        logic [1:0] offset;
    } burst_state_t;

    // Low two address bits for a burst beat.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] offset,
                                             input logic       linear);
        return linear ? (start + offset) : (start ^ offset);
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import sram_pkg::*;
#(
    parameter int unsigned ADDR_W = SRAM_ADDR_W,
    parameter int unsigned LANES  = SRAM_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              sel2_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              advance_n,
    input  logic              wr_lane_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              wr_all_n,
    input  logic              burst_linear,
    output acc_kind_e         acc_kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_mask
);

    burst_state_t      st_q;
    logic [ADDR_W-1:0] base_q;

    logic       chip_on, cpu_go, ctl_go, opening, want_wr;
    logic [1:0] offset_nx;

    assign chip_on   = !sel_n && sel_hi && !sel2_n;
    assign cpu_go    = !strobe_cpu_n && !sel_n;
    assign ctl_go    = !strobe_ctl_n;
    assign opening   = cpu_go || ctl_go;
    assign offset_nx = advance_n ? st_q.offset : st_q.offset + 2'd1;

    always_comb begin
        if (!wr_all_n)          acc_mask = '1;
        else if (!wr_lane_en_n) acc_mask = ~lane_sel_n;
        else                    acc_mask = '0;
    end
    assign want_wr = |acc_mask;

    always_comb begin
        acc_kind = ACC_NONE;
        acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], offset_nx, st_q.linear)};
        if (opening) begin
            acc_addr = addr;
            if (chip_on)
                acc_kind = (!cpu_go && want_wr) ? ACC_WRITE : ACC_READ;
        end else if (st_q.open) begin
            acc_kind = want_wr ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            base_q <= '0;
        end else if (opening) begin
            st_q.open   <= chip_on;
            st_q.linear <= burst_linear;
            st_q.offset <= 2'd0;
            base_q      <= addr;
        end else if (st_q.open) begin
            st_q.offset <= offset_nx;
        end
    end

endmodule

// File: rtl/lane_array.sv
module lane_array
    import sram_pkg::*;
#(
    parameter int unsigned ADDR_W = SRAM_ADDR_W,
    parameter int unsigned LANES  = SRAM_LANES,
    parameter int unsigned LANE_W = SRAM_LANE_W
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g])
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/read_pipe.sv
module read_pipe #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= 1'b0;
            arr_addr <= '0;
            dout_vld <= 1'b0;
            dout     <= '0;
        end else begin
            rd_q     <= rd_en;
            if (rd_en) arr_addr <= rd_addr;
            dout_vld <= rd_q;
            if (rd_q) dout <= arr_data;
        end
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sram_pkg::*;
#(
    parameter int unsigned ADDR_W = SRAM_ADDR_W,
    parameter int unsigned LANES  = SRAM_LANES,
    parameter int unsigned LANE_W = SRAM_LANE_W,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              sel2_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              advance_n,
    input  logic              wr_lane_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              wr_all_n,
    input  logic              drv_en_n,
    input  logic              burst_linear,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              dout_oe
);

    acc_kind_e         kind;
    logic [ADDR_W-1:0] acc_addr, arr_raddr;
    logic [LANES-1:0]  acc_mask, wr_mask;
    logic [DATA_W-1:0] arr_rdata;

    burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk, .rst, .addr, .sel_n, .sel_hi, .sel2_n,
        .strobe_cpu_n, .strobe_ctl_n, .advance_n,
        .wr_lane_en_n, .lane_sel_n, .wr_all_n, .burst_linear,
        .acc_kind(kind), .acc_addr(acc_addr), .acc_mask(acc_mask)
    );

    assign wr_mask = (kind == ACC_WRITE) ? acc_mask : '0;

    lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk, .wr_mask(wr_mask), .wr_addr(acc_addr), .wr_data(din),
        .rd_addr(arr_raddr), .rd_data(arr_rdata)
    );

    read_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk, .rst, .rd_en(kind == ACC_READ), .rd_addr(acc_addr),
        .arr_addr(arr_raddr), .arr_data(arr_rdata),
        .dout(dout), .dout_vld(dout_vld)
    );

    assign dout_oe = dout_vld && !drv_en_n;

endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 4,
    parameter int unsigned DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              sel_hi,
    input logic              sel2_n,
    input logic              strobe_cpu_n,
    input logic              strobe_ctl_n,
    input logic              drv_en_n,
    input logic              dout_vld,
    input logic              dout_oe
);

    logic selected, opening;
    assign selected = !sel_n && sel_hi && !sel2_n;
    assign opening  = !strobe_ctl_n || (!strobe_cpu_n && !sel_n);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dout_vld); // R1

    AST_OE_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> dout_vld); // R10

    AST_OE_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        drv_en_n |-> !dout_oe); // R10

    AST_CPU_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!strobe_cpu_n && selected) |=> ##1 dout_vld); // R8

    AST_DESELECT_DROP: assert property (@(posedge clk) disable iff (rst)
        (opening && !selected) |=> ##1 !dout_vld); // R9

endmodule

bind burst_sram sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_chk (
    .clk, .rst, .sel_n, .sel_hi, .sel2_n, .strobe_cpu_n, .strobe_ctl_n,
    .drv_en_n, .dout_vld, .dout_oe
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

    localparam int PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic sel_n = 1'b0, sel_hi = 1'b1, sel2_n = 1'b0;
    logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
    logic wr_lane_en_n = 1'b1, wr_all_n = 1'b1, drv_en_n = 1'b0, burst_linear = 1'b1;
    logic [3:0] lane_sel_n = 4'hF;
    logic [DW-1:0] dout;
    logic dout_vld, dout_oe;

    always #(PERIOD/2) clk = ~clk;

    burst_sram u0 (.*);

    int n_chk = 0, n_bad = 0;
    string tag = "R2";

    // Bench model state
    logic [DW-1:0] refm [1 << AW];
    logic          m_open, m_lin;
    logic [AW-1:0] m_base;
    logic [1:0]    m_off;
    logic          p1_en;
    logic [AW-1:0] p1_addr;
    logic          e_vld;
    logic [DW-1:0] e_dat;

    task automatic check(input logic ok, input string t, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] o,
                                           input logic lin);
        return lin ? 2'(s + o) : (s ^ o);
    endfunction

    task automatic model_edge();
        logic [3:0]    mask;
        logic          cpu_go, ctl_go, chip, wr;
        logic [AW-1:0] a;
        logic          do_rd, do_wr;
        e_vld = p1_en;
        if (p1_en) e_dat = refm[p1_addr];
        mask = !wr_all_n ? 4'hF : (!wr_lane_en_n ? ~lane_sel_n : 4'h0);
        wr = |mask;
        cpu_go = !strobe_cpu_n && !sel_n;
        ctl_go = !strobe_ctl_n;
        chip = !sel_n && sel_hi && !sel2_n;
        do_rd = 1'b0; do_wr = 1'b0; a = addr;
        if (cpu_go || ctl_go) begin
            m_open = chip; m_base = addr; m_off = 2'd0; m_lin = burst_linear;
            if (chip) begin
                if (!cpu_go && wr) do_wr = 1'b1; else do_rd = 1'b1;
            end
        end else if (m_open) begin
            if (!advance_n) m_off = m_off + 2'd1;
            a = {m_base[AW-1:2], exp_low(m_base[1:0], m_off, m_lin)};
            if (wr) do_wr = 1'b1; else do_rd = 1'b1;
        end
        if (do_wr)
            for (int i = 0; i < 4; i++)
                if (mask[i]) refm[a][i*9 +: 9] = din[i*9 +: 9];
        p1_en = do_rd;
        if (do_rd) p1_addr = a;
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(dout_vld === e_vld, {tag, " valid"}, DW'(dout_vld), DW'(e_vld));
        if (e_vld) check(dout === e_dat, {tag, " data"}, dout, e_dat);
        check(dout_oe === (e_vld && !drv_en_n), "R10 drive", DW'(dout_oe),
              DW'(e_vld && !drv_en_n));
    endtask

    task automatic idle();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; advance_n = 1'b1;
        wr_lane_en_n = 1'b1; wr_all_n = 1'b1; lane_sel_n = 4'hF;
        sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0;
    endtask

    task automatic open_ctl(input logic [AW-1:0] a, input logic lin, input logic wall,
                            input logic [DW-1:0] d);
        idle(); strobe_ctl_n = 1'b0; addr = a; burst_linear = lin;
        wr_all_n = ~wall; din = d;
        step();
    endtask

    task automatic open_cpu(input logic [AW-1:0] a, input logic lin);
        idle(); strobe_cpu_n = 1'b0; addr = a; burst_linear = lin;
        step();
    endtask

    task automatic beat(input logic adv, input logic [3:0] lanes_n, input logic lane_en,
                        input logic [DW-1:0] d);
        idle(); advance_n = ~adv; lane_sel_n = lanes_n; wr_lane_en_n = ~lane_en; din = d;
        step();
    endtask

    initial begin : watchdog
        #(PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5A17));
        m_open = 0; m_lin = 1; m_base = '0; m_off = '0; p1_en = 0; p1_addr = '0;
        e_vld = 0; e_dat = '0;
        repeat (3) @(negedge clk);
        tag = "R1";
        check(dout_vld === 1'b0, "R1 vld in reset", DW'(dout_vld), '0);
        check(dout_oe === 1'b0, "R1 oe in reset", DW'(dout_oe), '0);
        rst = 1'b0;
        step();

        // Prefill a 64-word window with linear all-lane write bursts (R5, R3)
        tag = "R5";
        for (int b = 0; b < 16; b++) begin
            open_ctl(AW'(b * 4), 1'b1, 1'b1, {4'h1, 32'(b * 4)});
            for (int k = 1; k < 4; k++) begin
                idle(); advance_n = 1'b0; wr_all_n = 1'b0; lane_sel_n = 4'h0;
                wr_lane_en_n = 1'b1; din = {4'h1, 32'(b * 4 + k)}; step();
            end
        end

        // Linear read burst from an offset start: 2,3,0,1 (R3)
        tag = "R3";
        open_cpu(AW'(6), 1'b1);
        for (int k = 0; k < 3; k++) beat(1'b1, 4'hF, 1'b0, '0);
        beat(1'b0, 4'hF, 1'b0, '0);   // held offset repeats the same word
        idle(); step(); step();

        // Interleaved read burst: start 01 -> 01,00,11,10 (R4)
        tag = "R4";
        open_cpu(AW'(9), 1'b0);
        for (int k = 0; k < 3; k++) beat(1'b1, 4'hF, 1'b0, '0);
        idle(); step(); step();
        check(refm[9][31:0] == 32'd9, "R4 word 9 kept", refm[9], 36'h100000009);

        // Partial lane writes, one and two lanes (R6), read back
        tag = "R6";
        open_ctl(AW'(20), 1'b1, 1'b0, '0);          // ctl opening, no write: read
        beat(1'b0, 4'b1110, 1'b1, 36'hFFFFFFFFF);  // lane 0 only
        beat(1'b1, 4'b0101, 1'b1, 36'hAAAAAAAAA);  // lanes 1 and 3
        beat(1'b0, 4'hF, 1'b1, 36'h123456789);     // lane enable but no lane: read
        open_cpu(AW'(20), 1'b1);
        beat(1'b1, 4'hF, 1'b0, '0);
        idle(); step(); step();

        // CPU-side opening is a read; write comes from the next edge (R8)
        tag = "R8";
        idle(); strobe_cpu_n = 1'b0; addr = AW'(30); wr_all_n = 1'b0; din = 36'h0BEEF0000;
        step();
        idle(); wr_all_n = 1'b0; din = 36'h0CAFE0001; step();
        open_cpu(AW'(30), 1'b1);
        idle(); step(); step();

        // CPU strobe with primary select high is ignored (R7)
        tag = "R7";
        open_cpu(AW'(40), 1'b1);
        idle(); sel_n = 1'b1; strobe_cpu_n = 1'b0; addr = AW'(50); advance_n = 1'b0; step();
        beat(1'b1, 4'hF, 1'b0, '0);
        idle(); step(); step();

        // Deselect during a burst: beat in flight appears, then valid drops (R9)
        tag = "R9";
        open_cpu(AW'(44), 1'b0);
        beat(1'b1, 4'hF, 1'b0, '0);
        idle(); strobe_ctl_n = 1'b0; sel_hi = 1'b0; step();
        check(dout_vld === 1'b1, "R9 in-flight beat", DW'(dout_vld), 36'd1);
        idle(); step();
        check(dout_vld === 1'b0, "R9 valid dropped", DW'(dout_vld), '0);

        // Idle edges with write controls do nothing (R11)
        tag = "R11";
        idle(); wr_all_n = 1'b0; din = '1; step();
        idle(); advance_n = 1'b0; wr_all_n = 1'b0; din = '1; step();
        open_cpu(AW'(45), 1'b1);
        idle(); step(); step();

        // Drive enable gates only the flag (R10)
        tag = "R10";
        open_cpu(AW'(12), 1'b1);
        idle(); drv_en_n = 1'b1; step();
        drv_en_n = 1'b1; step();
        check(dout === refm[12], "R10 data kept with drive off", dout, refm[12]);
        drv_en_n = 1'b0; idle(); step();

        // Constrained random traffic (R2 and the rest)
        tag = "R2";
        for (int it = 0; it < 3000; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            idle();
            drv_en_n = ($urandom_range(0, 7) == 0);
            addr = AW'($urandom_range(0, 63));
            burst_linear = $urandom_range(0, 1) == 1;
            din = {$urandom(), 4'($urandom())};
            advance_n = $urandom_range(0, 3) == 0;
            if ($urandom_range(0, 2) == 0) begin
                wr_lane_en_n = 1'b0; lane_sel_n = 4'($urandom());
            end
            if ($urandom_range(0, 9) == 0) wr_all_n = 1'b0;
            case (op)
                0: strobe_ctl_n = 1'b0;
                1: strobe_cpu_n = 1'b0;
                2: begin strobe_ctl_n = 1'b0; sel2_n = $urandom_range(0, 3) == 0; end
                3: begin strobe_cpu_n = 1'b0; sel_n = 1'b1; end
                default: ;
            endcase
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule